// File: doc/BRIEF.md
# Multi-Chip Event Frame Packer

The packer writes one complete event record into a 64-bit-wide event RAM. Each RAM row carries four 16-bit lanes, where lane k occupies bits [16k+15:16k]. The record has three parts. A seven-row status header comes first. Next come `N_GROUPS` channel groups, and each group holds one channel from each of four sampling chips placed side by side, one chip per lane. A single footer row closes the record. The rows are written contiguously from the parameter `BASE_ROW` upward.

A start strobe latches every header field, the four per-chip stop positions and the four per-chip region-of-interest (ROI) widths. The frame is then written with one row per cycle. The exception is the sample phase, where a row is written only when the sample source presents a valid 4-lane word while `sample_ready_o` is high. The sample row count in each group is the largest of the four latched ROI widths, so every chip contributes the same number of rows. A one-cycle `done_o` marks the end of the record.

The controller has eight states. ST_IDLE goes to ST_HEAD on start. ST_HEAD stays for seven rows and then goes to ST_GID. After that the order is ST_GID, then ST_GSTOP, then ST_GROI. ST_GROI goes to ST_DATA when the sample count is non-zero. Otherwise it goes to the next ST_GID, or to ST_FOOT after the last group. ST_DATA goes to the next ST_GID or to ST_FOOT after its last accepted sample. ST_FOOT goes to ST_DONE, and ST_DONE returns to ST_IDLE.

Top module: `evt_frame_packer`

## Requirements
- R1: After reset, and whenever idle, `wr_en_o`, `sample_ready_o` and `done_o` are low. A start strobe raised while a frame is in progress is ignored: no second frame follows and the write count is unchanged.
- R2: Header row 0 holds 0xFB01 in lane 0, the packet length in lane 1, the version in lane 2 and 0 in lane 3.
- R3: Header rows 1 and 2 (external and internal trigger ID) each hold event counter bits [31:16] in lane 0, bits [15:0] in lane 1, the trigger type in lane 2 and 0 in lane 3. Row 4 holds temperature k in lane k. Row 5 holds DAC k in lane k, and row 6 holds DAC 4+k in lane k.
- R4: Header row 3 lane 0 is {4'h0, crate ID, 4'h8, board ID}. Lanes 1 to 3 are zero.
- R5: Each group opens with an ID row whose lane k is (k<<4)|g for group g.
- R6: The ID row is followed by a row holding stop position k in lane k, and then by a row holding ROI width k in lane k.
- R7: Each group then carries exactly max(ROI widths) sample rows, each a copy of an accepted 64-bit sample word in arrival order. With all widths zero there are no sample rows.
- R8: Rows are written to consecutive addresses starting at `BASE_ROW`. Group g starts at BASE_ROW + 7 + g*(3 + max ROI), and the total is 8 + N_GROUPS*(3 + max ROI) rows.
- R9: The footer row, written last, holds 0x4242 in lane 0, 0x04FE in lane 1 and zero in lanes 2 and 3.
- R10: `done_o` is high for exactly one cycle, the cycle after the footer write.
- R11: `sample_ready_o` is high only while sample rows are due. A sample word offered without ready, or offered with valid low, writes nothing.
- R12: The first header row is written in the cycle after the clock edge that accepts the start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame (taken only when idle) |
| pkt_len_i | input | 16 | Packet length field |
| version_i | input | 16 | Version field |
| trig_type_i | input | 16 | Trigger type field |
| evt_count_i | input | 32 | Event counter |
| crate_id_i | input | 4 | Crate ID nibble |
| board_id_i | input | 4 | Board ID nibble |
| temps_i | input | 64 | Four temperatures, lane k = sensor k |
| dacs_i | input | 128 | Eight DAC settings, DAC k at [16k+15:16k] |
| stop_pos_i | input | 64 | Per-chip stop positions |
| roi_i | input | 64 | Per-chip ROI widths |
| sample_valid_i | input | 1 | Sample word valid |
| sample_i | input | 64 | 4-lane sample word |
| sample_ready_o | output | 1 | Sample row accepted this cycle if valid |
| wr_en_o | output | 1 | RAM write enable |
| wr_addr_o | output | ADDR_W | RAM row address |
| wr_data_o | output | 64 | RAM row data |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The write port is driven combinationally from the state, so a row appears in the same cycle in which its state is current. The first row is due one cycle after start is taken, each further non-sample row follows one cycle later, and a sample row appears in the very cycle in which valid and ready meet. `done_o` is due exactly one cycle after the footer write. The bench drives inputs and records the write port on the falling edge, and it tags each recorded write and the `done_o` pulse with a cycle count measured from the start edge. Those cycle numbers are compared with the offsets above, and the stored rows are compared with values computed from the requirements.

// File: rtl/evtpk_pkg.sv
package evtpk_pkg;
    localparam int LANES    = 4;
    localparam int LANE_W   = 16;
    localparam int ROW_W    = LANES * LANE_W;
    localparam int HDR_ROWS = 7;
    localparam int GRP_PRE  = 3;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [ROW_W-1:0]  row_t;

    localparam lane_t START_FLAG = 16'hFB01;
    localparam lane_t CRC_FAKE   = 16'h4242;
    localparam lane_t END_FLAG   = 16'h04FE;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HEAD, ST_GID, ST_GSTOP, ST_GROI, ST_DATA, ST_FOOT, ST_DONE
    } pk_state_e;

    typedef enum logic [1:0] {GSEL_ID, GSEL_STOP, GSEL_ROI} gsel_e;

    typedef struct packed {
        lane_t         length;
        lane_t         version;
        lane_t         trig_type;
        logic [31:0]   evt_count;
        logic [3:0]    crate;
        logic [3:0]    board;
        row_t          temps;
        logic [127:0]  dacs;
    } hdr_fields_t;
endpackage

// File: rtl/evtpk_head_rows.sv
module evtpk_head_rows
    import evtpk_pkg::*;
(
    input  hdr_fields_t f_i,
    input  logic [2:0]  idx_i,
    output row_t        row_o
);
    always_comb begin
        unique case (idx_i)
            3'd0:    row_o = {16'h0000, f_i.version, f_i.length, START_FLAG};
            3'd1,
            3'd2:    row_o = {16'h0000, f_i.trig_type, f_i.evt_count[15:0], f_i.evt_count[31:16]};
            3'd3:    row_o = {48'h0, 4'h0, f_i.crate, 4'h8, f_i.board};
            3'd4:    row_o = f_i.temps;
            3'd5:    row_o = f_i.dacs[63:0];
            3'd6:    row_o = f_i.dacs[127:64];
            default: row_o = '0;
        endcase
    end
endmodule

// File: rtl/evtpk_group_rows.sv
module evtpk_group_rows
    import evtpk_pkg::*;
#(
    parameter int GRP_W = 4
) (
    input  logic [GRP_W-1:0] grp_i,
    input  gsel_e            sel_i,
    input  row_t             stop_i,
    input  row_t             roi_i,
    output row_t             row_o
);
    row_t id_row;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign id_row[k*LANE_W +: LANE_W] = LANE_W'(k << 4) | LANE_W'(grp_i);
    end

    always_comb begin
        unique case (sel_i)
            GSEL_ID:   row_o = id_row;
            GSEL_STOP: row_o = stop_i;
            GSEL_ROI:  row_o = roi_i;
            default:   row_o = '0;
        endcase
    end
endmodule

// File: rtl/evtpk_roi_max.sv
module evtpk_roi_max
    import evtpk_pkg::*;
(
    input  row_t  widths_i,
    output lane_t max_o
);
    always_comb begin
        max_o = '0;
        for (int k = 0; k < LANES; k++) begin
            if (widths_i[k*LANE_W +: LANE_W] > max_o)
                max_o = widths_i[k*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/evt_frame_packer.sv
module evt_frame_packer
    import evtpk_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_ROW = 16'h2000,
    parameter int unsigned       N_GROUPS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [15:0]       pkt_len_i,
    input  logic [15:0]       version_i,
    input  logic [15:0]       trig_type_i,
    input  logic [31:0]       evt_count_i,
    input  logic [3:0]        crate_id_i,
    input  logic [3:0]        board_id_i,
    input  logic [63:0]       temps_i,
    input  logic [127:0]      dacs_i,
    input  logic [63:0]       stop_pos_i,
    input  logic [63:0]       roi_i,
    input  logic              sample_valid_i,
    input  logic [63:0]       sample_i,
    output logic              sample_ready_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [63:0]       wr_data_o,
    output logic              done_o
);
    localparam int GRP_W = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(N_GROUPS - 1);
    localparam logic [2:0] LAST_HDR = 3'(HDR_ROWS - 1);

    pk_state_e         state_q, state_d;
    hdr_fields_t       fields_q;
    row_t              stop_q, roi_q;
    logic [2:0]        hdr_idx_q;
    logic [GRP_W-1:0]  grp_q;
    lane_t             smp_q;
    lane_t             nsmp;
    logic [ADDR_W-1:0] addr_q;
    logic              fire, last_smp, grp_adv, take_start;
    gsel_e             gsel;
    row_t              head_row, grp_row;

    evtpk_head_rows u_head (
        .f_i   (fields_q),
        .idx_i (hdr_idx_q),
        .row_o (head_row)
    );

    evtpk_group_rows #(.GRP_W(GRP_W)) u_grp (
        .grp_i  (grp_q),
        .sel_i  (gsel),
        .stop_i (stop_q),
        .roi_i  (roi_q),
        .row_o  (grp_row)
    );

    evtpk_roi_max u_max (
        .widths_i (roi_q),
        .max_o    (nsmp)
    );

    assign take_start = (state_q == ST_IDLE) && start_i;
    assign fire       = (state_q == ST_DATA) && sample_valid_i;
    assign last_smp   = (smp_q == nsmp - 16'd1);
    assign grp_adv    = (state_d == ST_GID) &&
                        ((state_q == ST_GROI) || (state_q == ST_DATA));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_HEAD;
            ST_HEAD:  if (hdr_idx_q == LAST_HDR) state_d = ST_GID;
            ST_GID:   state_d = ST_GSTOP;
            ST_GSTOP: state_d = ST_GROI;
            ST_GROI: begin
                if (nsmp != '0)             state_d = ST_DATA;
                else if (grp_q == LAST_GRP) state_d = ST_FOOT;
                else                        state_d = ST_GID;
            end
            ST_DATA: begin
                if (fire && last_smp)
                    state_d = (grp_q == LAST_GRP) ? ST_FOOT : ST_GID;
            end
            ST_FOOT:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            fields_q  <= '0;
            stop_q    <= '0;
            roi_q     <= '0;
            hdr_idx_q <= '0;
            grp_q     <= '0;
            smp_q     <= '0;
            addr_q    <= BASE_ROW;
        end else begin
            state_q <= state_d;
            if (take_start) begin
                fields_q  <= '{length: pkt_len_i, version: version_i,
                               trig_type: trig_type_i, evt_count: evt_count_i,
                               crate: crate_id_i, board: board_id_i,
                               temps: temps_i, dacs: dacs_i};
                stop_q    <= stop_pos_i;
                roi_q     <= roi_i;
                hdr_idx_q <= '0;
                grp_q     <= '0;
                smp_q     <= '0;
                addr_q    <= BASE_ROW;
            end else begin
                if (wr_en_o)              addr_q    <= addr_q + 1'b1;
                if (state_q == ST_HEAD)   hdr_idx_q <= hdr_idx_q + 3'd1;
                if (state_q == ST_GROI)   smp_q     <= '0;
                else if (fire)            smp_q     <= smp_q + 16'd1;
                if (grp_adv)              grp_q     <= grp_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wr_en_o        = 1'b0;
        wr_data_o      = '0;
        sample_ready_o = 1'b0;
        done_o         = 1'b0;
        gsel           = GSEL_ID;
        unique case (state_q)
            ST_IDLE: ;
            ST_HEAD: begin
                wr_en_o   = 1'b1;
                wr_data_o = head_row;
            end
            ST_GID: begin
                wr_en_o   = 1'b1;
                wr_data_o = grp_row;
            end
            ST_GSTOP: begin
                gsel      = GSEL_STOP;
                wr_en_o   = 1'b1;
                wr_data_o = grp_row;
            end
            ST_GROI: begin
                gsel      = GSEL_ROI;
                wr_en_o   = 1'b1;
                wr_data_o = grp_row;
            end
            ST_DATA: begin
                sample_ready_o = 1'b1;
                wr_en_o        = sample_valid_i;
                wr_data_o      = sample_i;
            end
            ST_FOOT: begin
                wr_en_o   = 1'b1;
                wr_data_o = {32'h0, END_FLAG, CRC_FAKE};
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign wr_addr_o = addr_q;

    // ---------------- assertions ----------------
    logic              have_prev_q;
    logic [ADDR_W-1:0] prev_addr_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev_q <= 1'b0;
            prev_addr_q <= '0;
        end else if (take_start) begin
            have_prev_q <= 1'b0;
        end else if (wr_en_o) begin
            have_prev_q <= 1'b1;
            prev_addr_q <= wr_addr_o;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!wr_en_o && !sample_ready_o && !done_o));

    p_rows_contig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && have_prev_q) |-> (wr_addr_o == prev_addr_q + 1'b1));

    p_smp_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (smp_q < nsmp));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_foot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(wr_en_o) &&
                           $past(wr_data_o) == {32'h0, END_FLAG, CRC_FAKE}));

    p_first_row_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take_start |=> (wr_en_o && wr_addr_o == BASE_ROW));
endmodule

// File: tb/evt_frame_packer_tb_top.sv
module evt_frame_packer_tb_top;
    localparam int          ADDR_W = 16;
    localparam logic [15:0] BASE   = 16'h2000;
    localparam int          NG     = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [15:0]   pkt_len_i = 16'h0ABC, version_i = 16'h0123, trig_type_i = 16'h5A5A;
    logic [31:0]   evt_count_i = 32'hDEAD_BEEF;
    logic [3:0]    crate_id_i = 4'h3, board_id_i = 4'h5;
    logic [63:0]   temps_i, stop_pos_i, roi_i = '0, sample_i = '0;
    logic [127:0]  dacs_i;
    logic          sample_valid_i = 1'b0;
    logic          sample_ready_o, wr_en_o, done_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [63:0]   wr_data_o;

    always #2 clk = ~clk;

    evt_frame_packer #(.ADDR_W(ADDR_W), .BASE_ROW(BASE), .N_GROUPS(NG)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .pkt_len_i(pkt_len_i), .version_i(version_i), .trig_type_i(trig_type_i),
        .evt_count_i(evt_count_i), .crate_id_i(crate_id_i), .board_id_i(board_id_i),
        .temps_i(temps_i), .dacs_i(dacs_i), .stop_pos_i(stop_pos_i), .roi_i(roi_i),
        .sample_valid_i(sample_valid_i), .sample_i(sample_i),
        .sample_ready_o(sample_ready_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .done_o(done_o)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic [63:0] mem [0:2047];
    int  wr_cnt, last_wr_cyc, done_cnt, done_cyc, n_acc, bad_ready;
    bit  first_ok, late_wr;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int n);
        logic [63:0] r;
        for (int k = 0; k < 4; k++) r[k*16 +: 16] = 16'(n * 4 + k + 16'h0100);
        return r;
    endfunction

    function automatic int roi_max(input logic [63:0] w);
        int m = 0;
        for (int k = 0; k < 4; k++) if (int'(w[k*16 +: 16]) > m) m = int'(w[k*16 +: 16]);
        return m;
    endfunction

    task automatic run_frame(input logic [63:0] widths, input bit gapped, input bit poke);
        int cyc, n, off, nm;
        nm = roi_max(widths);
        roi_i = widths;
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        wr_cnt = 0; done_cnt = 0; done_cyc = -1; last_wr_cyc = -1;
        n = 0; bad_ready = 0; late_wr = 1'b0; first_ok = 1'b0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        cyc = 0;
        while (cyc < 6000 && !(done_cyc >= 0 && cyc > done_cyc + 3)) begin
            if (cyc == 0) first_ok = wr_en_o && (wr_addr_o == BASE);
            if (wr_en_o) begin
                off = int'(wr_addr_o) - int'(BASE);
                if (off >= 0 && off < 2048) mem[off] = wr_data_o;
                wr_cnt++;
                last_wr_cyc = cyc;
                if (done_cyc >= 0) late_wr = 1'b1;
                if (sample_ready_o) begin
                    if (off < 7 || ((off - 7) % (3 + nm)) < 3) bad_ready++;
                    n++;
                end
            end
            if (done_o) begin done_cnt++; if (done_cyc < 0) done_cyc = cyc; end
            start_i = poke && (cyc == 15);
            sample_valid_i = gapped ? ((cyc % 3) != 2) : 1'b1;
            sample_i = sample_valid_i ? pat(n) : 64'hFFFF_FFFF_FFFF_FFFF;
            @(negedge clk);
            cyc++;
        end
        sample_valid_i = 1'b0;
        start_i = 1'b0;
        n_acc = n;
    endtask

    function automatic logic [63:0] exp_row(input int off, input int nm);
        int g, r;
        logic [63:0] e;
        e = '0;
        if (off == 0) e = {16'h0, version_i, pkt_len_i, 16'hFB01};
        else if (off == 1 || off == 2) e = {16'h0, trig_type_i, evt_count_i[15:0], evt_count_i[31:16]};
        else if (off == 3) e = {48'h0, 4'h0, crate_id_i, 4'h8, board_id_i};
        else if (off == 4) e = temps_i;
        else if (off == 5) e = dacs_i[63:0];
        else if (off == 6) e = dacs_i[127:64];
        else if (off < 7 + NG * (3 + nm)) begin
            g = (off - 7) / (3 + nm);
            r = (off - 7) % (3 + nm);
            if (r == 0) for (int k = 0; k < 4; k++) e[k*16 +: 16] = 16'((k << 4) | g);
            else if (r == 1) e = stop_pos_i;
            else if (r == 2) e = roi_i;
            else e = pat(g * nm + r - 3);
        end else e = {32'h0, 16'h04FE, 16'h4242};
        return e;
    endfunction

    task automatic check_rows(input int nm);
        int total, r;
        string tag;
        total = 8 + NG * (3 + nm);
        for (int off = 0; off < total; off++) begin
            r = (off - 7) % (3 + nm);
            if (off == 0) tag = "R2 head row0";
            else if (off == 3) tag = "R4 board row";
            else if (off < 7) tag = "R3 head rows";
            else if (off == total - 1) tag = "R9 footer";
            else if (r == 0) tag = "R5 group id";
            else if (r < 3) tag = "R6 stop/roi";
            else tag = "R7 sample row";
            check(mem[off] === exp_row(off, nm), tag, mem[off], exp_row(off, nm));
        end
        check(wr_cnt == total, "R8 total rows", 64'(wr_cnt), 64'(total));
        check(n_acc == NG * nm, "R7 samples accepted", 64'(n_acc), 64'(NG * nm));
        check(first_ok, "R12 first row one cycle after start", 64'(first_ok), 64'd1);
        check(done_cnt == 1 && done_cyc == last_wr_cyc + 1, "R10 done pulse",
              64'(done_cyc), 64'(last_wr_cyc + 1));
        check(!late_wr, "R1 no write after done", 64'(late_wr), 64'd0);
        check(bad_ready == 0, "R11 ready only on sample rows", 64'(bad_ready), 64'd0);
    endtask

    task automatic t_reset;
        check(!wr_en_o && !sample_ready_o && !done_o, "R1 reset state",
              {61'h0, wr_en_o, sample_ready_o, done_o}, 64'h0);
    endtask

    task automatic t_equal_roi;
        run_frame({16'd4, 16'd4, 16'd4, 16'd4}, 1'b0, 1'b0);
        check_rows(4);
    endtask

    task automatic t_unequal_gapped;
        run_frame({16'd2, 16'd5, 16'd7, 16'd3}, 1'b1, 1'b0);
        check_rows(7);
        check(mem[7 + 9 * 10] === exp_row(97, 7), "R8 group 9 start row", mem[97], exp_row(97, 7));
    endtask

    task automatic t_zero_roi;
        run_frame(64'h0, 1'b0, 1'b0);
        check_rows(0);
    endtask

    task automatic t_busy_start;
        run_frame({16'd3, 16'd1, 16'd0, 16'd2}, 1'b0, 1'b1);
        check_rows(3);
    endtask

    task automatic t_wide_roi;
        run_frame({16'd100, 16'd100, 16'd100, 16'd100}, 1'b0, 1'b0);
        check_rows(100);
    endtask

    task automatic t_idle_samples;
        int hits = 0;
        sample_valid_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sample_i = pat(500 + i);
            @(negedge clk);
            if (wr_en_o || sample_ready_o || done_o) hits++;
        end
        sample_valid_i = 1'b0;
        check(hits == 0, "R11 idle samples ignored", 64'(hits), 64'd0);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            temps_i[k*16 +: 16]    = 16'h7E00 + 16'(k);
            stop_pos_i[k*16 +: 16] = 16'h0300 + 16'(k * 7);
        end
        for (int k = 0; k < 8; k++) dacs_i[k*16 +: 16] = 16'hD000 + 16'(k * 16'h111);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_equal_roi();
        t_idle_samples();
        t_unequal_gapped();
        t_zero_roi();
        t_busy_start();
        t_wide_roi();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule